// File: doc/BRIEF.md
# CR-field mask-test vector sequencer

This block walks a run of 4-bit condition fields, one element per clock, and reduces each field to a single bit. For every field it compares each of the four bits with an expected-value pattern. Only the bits enabled by a 4-bit mask take part. The per-bit outcomes are then merged with either OR or AND, chosen per operation. The block reads the fields through a simple combinational indexed read port and drives write requests towards an integer register file and a condition-field file.

The element results go to one of three destinations:

- **Scalar integer.** The results fill successive bits of one integer register, starting at its least significant bit. Bits not covered by the run keep the register's prior value, which the caller supplies at start. A single full-width write is issued once the run completes. Optionally, a summary of that written value is produced for condition field 1.
- **Integer vector.** Each result is written to bit 0 of successive integer registers.
- **Condition bit.** Each result is written to one selected bit of one selected condition field.

A one-cycle start pulse latches every operand. `busy` covers the run and `done` marks its end. The condition fields are enumerated in natural order: element i of a vector source reads field base+i.

Top module: `crmask_seq`

## Requirements
- R1: A condition field is a 4-bit vector f[3:0] (f[3]=lt, f[2]=gt, f[1]=eq, f[0]=summary overflow). For each k, hit_k = mask[k] AND (mode[k] == f[k]).
- R2: With `use_or`=1 the element result is hit3|hit2|hit1|hit0. With `use_or`=0 it is hit3&hit2&hit1&hit0, so any zero mask bit gives 0.
- R3: With `src_vec`=1, element i reads field (cr_base+i) modulo 2^CR_IDX_W. With `src_vec`=0, every element reads field cr_base. The read index is on `cr_rd_idx` in the element's cycle.
- R4: With `dst_sel`=2'b00 (scalar integer), the result of element i lands in bit i of `prior_int`, and the other bits are kept. One write to `int_base` carries this value, in the cycle after the last element. No other write is made.
- R5: With `dst_sel`=2'b01 (integer vector), element i writes register (int_base+i) modulo 2^INT_IDX_W in its own cycle. The data is the result in bit 0 and zeros elsewhere.
- R6: With `dst_sel`=2'b10 (condition bit), each element writes its result to field bft[2:0]. The bit selector s=bft[4:3] counts from lt, so `cr_wbit_idx` = 3-s.
- R7: With `rc`=1 and the scalar integer destination, `cr1_we` rises together with the integer write. `cr1_wdata` is 4'b1000 for a negative value, 4'b0100 for a positive value and 4'b0010 for zero. `rc` has no effect on the other destinations.
- R8: Elements are visited in natural ascending order, one per clock, with no reordering inside groups of eight.
- R9: A vector length of 0 makes no read-driven write and no integer or CR1 write. `done` follows in the cycle after start.
- R10: `busy` is high from the cycle after start until the last write. A start seen while a run is in progress is ignored and leaves that run's writes unchanged. Writes happen only while busy.
- R11: `done` is a single-cycle pulse in the cycle after the last write, with no write in that cycle.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, latches all operands when idle |
| vl | input | VL_W | Element count, 0 to DATA_W |
| src_vec | input | 1 | 1: source fields step with the element index |
| dst_sel | input | 2 | 00 scalar integer, 01 integer vector, 1x condition bit |
| use_or | input | 1 | 1: OR combine, 0: AND combine |
| mask | input | 4 | Bit enables for the test |
| mode | input | 4 | Expected bit values |
| cr_base | input | CR_IDX_W | First source field index |
| int_base | input | INT_IDX_W | Integer destination register index |
| bft | input | 5 | Condition-bit target: [2:0] field, [4:3] bit selector |
| rc | input | 1 | Request a CR1 summary of the scalar result |
| prior_int | input | DATA_W | Prior value of the scalar destination register |
| cr_rd_idx | output | CR_IDX_W | Field read index |
| cr_rd_data | input | 4 | Field read data, same cycle |
| int_we | output | 1 | Integer write enable |
| int_waddr | output | INT_IDX_W | Integer write address |
| int_wdata | output | DATA_W | Integer write data |
| cr_we | output | 1 | Condition-bit write enable |
| cr_waddr | output | CR_IDX_W | Condition-bit write field |
| cr_wbit_idx | output | 2 | Index into f[3:0] of the written bit |
| cr_wval | output | 1 | Written bit value |
| cr1_we | output | 1 | CR1 summary write enable |
| cr1_wdata | output | 4 | CR1 summary as f[3:0] |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its defaults: 64 condition fields, 32 integer registers and 64-bit data. With these values, a full run of 64 elements fills every bit of the scalar destination. A source base of 60 makes the field index wrap past the top of the file within that run. An integer base of 30 makes the vector destination wrap its register index. Prior values and mask/mode choices are picked so that the CR1 summary takes each of its negative, positive and zero codes.

// File: rtl/crmask_pkg.sv
package crmask_pkg;

  localparam int CRF_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  localparam logic [1:0] DST_INT_SCALAR = 2'b00;
  localparam logic [1:0] DST_INT_VEC    = 2'b01;

  // field index carried in the low three bits of the target code
  function automatic logic [2:0] crm_tgt_field(input logic [4:0] tgt);
    return tgt[2:0];
  endfunction

  // selector counts from lt (vector bit 3) downwards
  function automatic logic [1:0] crm_tgt_bitpos(input logic [4:0] tgt);
    return 2'd3 - tgt[4:3];
  endfunction

endpackage

// File: rtl/crmask_reduce.sv
module crmask_reduce
  import crmask_pkg::*;
(
  input  logic [CRF_W-1:0] mask,
  input  logic [CRF_W-1:0] mode,
  input  logic [CRF_W-1:0] fld,
  input  logic             use_or,
  output logic             res
);

  logic [CRF_W-1:0] hits;

  for (genvar k = 0; k < CRF_W; k++) begin : g_bit
    assign hits[k] = mask[k] & ~(mode[k] ^ fld[k]);
  end

  assign res = use_or ? |hits : &hits;

endmodule

// File: rtl/crmask_ctrl.sv
module crmask_ctrl
  import crmask_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] vl,
  input  logic            need_flush,
  output logic            accept,
  output logic            ev_elem,
  output logic            ev_flush,
  output logic            busy,
  output logic            done,
  output logic [VL_W-1:0] elem_idx
);

  seq_state_e      state;
  logic [VL_W-1:0] vl_q;
  logic            at_last;

  assign accept  = start && (state == ST_IDLE);
  assign at_last = (elem_idx == vl_q - VL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      vl_q     <= '0;
      elem_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            vl_q     <= vl;
            elem_idx <= '0;
            state    <= (vl == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (at_last) state <= need_flush ? ST_FLUSH : ST_DONE;
          else         elem_idx <= elem_idx + VL_W'(1);
        end
        ST_FLUSH: state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign ev_elem  = (state == ST_RUN);
  assign ev_flush = (state == ST_FLUSH);
  assign busy     = ev_elem || ev_flush;
  assign done     = (state == ST_DONE);

endmodule

// File: rtl/crmask_accum.sv
module crmask_accum #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] prior,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              set_val,
  output logic [DATA_W-1:0] value,
  output logic [3:0]        summary
);

  // sign/zero classification, result as {lt, gt, eq, so}
  function automatic logic [3:0] classify(input logic [DATA_W-1:0] v);
    logic is_zero;
    logic is_neg;
    is_zero = (v == '0);
    is_neg  = v[DATA_W-1];
    return {is_neg, !is_neg && !is_zero, is_zero, 1'b0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (load)   value <= prior;
    else if (set_en) value[set_idx] <= set_val;
  end

  assign summary = classify(value);

endmodule

// File: rtl/crmask_seq.sv
module crmask_seq
  import crmask_pkg::*;
#(
  parameter int CR_IDX_W  = 6,
  parameter int INT_IDX_W = 5,
  parameter int DATA_W    = 64,
  localparam int VL_W     = $clog2(DATA_W) + 1,
  localparam int BIT_W    = $clog2(DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [VL_W-1:0]      vl,
  input  logic                 src_vec,
  input  logic [1:0]           dst_sel,
  input  logic                 use_or,
  input  logic [CRF_W-1:0]     mask,
  input  logic [CRF_W-1:0]     mode,
  input  logic [CR_IDX_W-1:0]  cr_base,
  input  logic [INT_IDX_W-1:0] int_base,
  input  logic [4:0]           bft,
  input  logic                 rc,
  input  logic [DATA_W-1:0]    prior_int,
  output logic [CR_IDX_W-1:0]  cr_rd_idx,
  input  logic [CRF_W-1:0]     cr_rd_data,
  output logic                 int_we,
  output logic [INT_IDX_W-1:0] int_waddr,
  output logic [DATA_W-1:0]    int_wdata,
  output logic                 cr_we,
  output logic [CR_IDX_W-1:0]  cr_waddr,
  output logic [1:0]           cr_wbit_idx,
  output logic                 cr_wval,
  output logic                 cr1_we,
  output logic [CRF_W-1:0]     cr1_wdata,
  output logic                 busy,
  output logic                 done
);

  logic                 accept;
  logic                 ev_elem;
  logic                 ev_flush;
  logic [VL_W-1:0]      elem_idx;
  logic                 elem_res;
  logic [DATA_W-1:0]    acc_value;
  logic [3:0]           acc_summary;

  logic                 src_vec_q;
  logic [1:0]           dst_q;
  logic                 use_or_q;
  logic [CRF_W-1:0]     mask_q;
  logic [CRF_W-1:0]     mode_q;
  logic [CR_IDX_W-1:0]  cr_base_q;
  logic [INT_IDX_W-1:0] int_base_q;
  logic [4:0]           bft_q;
  logic                 rc_q;

  logic dst_is_scalar;
  logic dst_is_vec;
  logic dst_is_cr;

  assign dst_is_scalar = (dst_q == DST_INT_SCALAR);
  assign dst_is_vec    = (dst_q == DST_INT_VEC);
  assign dst_is_cr     = dst_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_vec_q  <= 1'b0;
      dst_q      <= '0;
      use_or_q   <= 1'b0;
      mask_q     <= '0;
      mode_q     <= '0;
      cr_base_q  <= '0;
      int_base_q <= '0;
      bft_q      <= '0;
      rc_q       <= 1'b0;
    end else if (accept) begin
      src_vec_q  <= src_vec;
      dst_q      <= dst_sel;
      use_or_q   <= use_or;
      mask_q     <= mask;
      mode_q     <= mode;
      cr_base_q  <= cr_base;
      int_base_q <= int_base;
      bft_q      <= bft;
      rc_q       <= rc;
    end
  end

  crmask_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vl         (vl),
    .need_flush (dst_is_scalar),
    .accept     (accept),
    .ev_elem    (ev_elem),
    .ev_flush   (ev_flush),
    .busy       (busy),
    .done       (done),
    .elem_idx   (elem_idx)
  );

  // natural field order: base plus element index, wrapping in the file
  assign cr_rd_idx = src_vec_q ? (cr_base_q + CR_IDX_W'(elem_idx)) : cr_base_q;

  crmask_reduce u_reduce (
    .mask   (mask_q),
    .mode   (mode_q),
    .fld    (cr_rd_data),
    .use_or (use_or_q),
    .res    (elem_res)
  );

  crmask_accum #(.DATA_W(DATA_W)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .prior   (prior_int),
    .set_en  (ev_elem && dst_is_scalar),
    .set_idx (elem_idx[BIT_W-1:0]),
    .set_val (elem_res),
    .value   (acc_value),
    .summary (acc_summary)
  );

  assign int_we    = (ev_elem && dst_is_vec) || ev_flush;
  assign int_waddr = ev_flush ? int_base_q : (int_base_q + INT_IDX_W'(elem_idx));
  assign int_wdata = ev_flush ? acc_value : {{(DATA_W-1){1'b0}}, elem_res};

  assign cr_we       = ev_elem && dst_is_cr;
  assign cr_waddr    = CR_IDX_W'(crm_tgt_field(bft_q));
  assign cr_wbit_idx = crm_tgt_bitpos(bft_q);
  assign cr_wval     = elem_res;

  assign cr1_we    = ev_flush && rc_q;
  assign cr1_wdata = acc_summary;

endmodule

// File: rtl/crmask_seq_chk.sv
module crmask_seq_chk #(
  parameter int CR_IDX_W = 6,
  parameter int VL_W     = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                done,
  input logic                int_we,
  input logic                cr_we,
  input logic                cr1_we,
  input logic                ev_elem,
  input logic                ev_flush,
  input logic [VL_W-1:0]     elem_idx,
  input logic                src_vec_q,
  input logic [CR_IDX_W-1:0] cr_rd_idx
);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !int_we && !cr_we));

  // R10
  write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_we || cr_we) |-> busy);

  // R6
  one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_we && cr_we));

  // R7
  cr1_with_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr1_we |-> (int_we && ev_flush));

  // R8
  elem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_elem && $past(ev_elem)) |-> (elem_idx == $past(elem_idx) + VL_W'(1)));

  // R3
  scalar_src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_elem && $past(ev_elem) && !src_vec_q) |-> $stable(cr_rd_idx));

  // R4
  flush_after_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |-> $past(ev_elem));

endmodule

bind crmask_seq crmask_seq_chk #(.CR_IDX_W(CR_IDX_W), .VL_W(VL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .int_we    (int_we),
  .cr_we     (cr_we),
  .cr1_we    (cr1_we),
  .ev_elem   (ev_elem),
  .ev_flush  (ev_flush),
  .elem_idx  (elem_idx),
  .src_vec_q (src_vec_q),
  .cr_rd_idx (cr_rd_idx)
);

// File: tb/crmask_seq_tb.sv
module crmask_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl = '0;
  logic        src_vec = 1'b0;
  logic [1:0]  dst_sel = '0;
  logic        use_or = 1'b0;
  logic [3:0]  mask = '0;
  logic [3:0]  mode = '0;
  logic [5:0]  cr_base = '0;
  logic [4:0]  int_base = '0;
  logic [4:0]  bft = '0;
  logic        rc = 1'b0;
  logic [63:0] prior_int = '0;
  logic [5:0]  cr_rd_idx;
  logic [3:0]  cr_rd_data;
  logic        int_we;
  logic [4:0]  int_waddr;
  logic [63:0] int_wdata;
  logic        cr_we;
  logic [5:0]  cr_waddr;
  logic [1:0]  cr_wbit_idx;
  logic        cr_wval;
  logic        cr1_we;
  logic [3:0]  cr1_wdata;
  logic        busy;
  logic        done;

  logic [3:0]  crf [64];
  assign cr_rd_data = crf[cr_rd_idx];

  int n_run  = 0;
  int n_fail = 0;

  // operation under test
  int          op_vl;
  logic        op_src_vec;
  logic [1:0]  op_dst;
  logic        op_or;
  logic [3:0]  op_mask;
  logic [3:0]  op_mode;
  int          op_crb;
  int          op_intb;
  logic [4:0]  op_bft;
  logic        op_rc;
  logic [63:0] op_prior;
  logic        op_glitch;
  string       dtag;

  always #(CLK_PERIOD/2) clk = ~clk;

  crmask_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .src_vec(src_vec),
    .dst_sel(dst_sel), .use_or(use_or), .mask(mask), .mode(mode),
    .cr_base(cr_base), .int_base(int_base), .bft(bft), .rc(rc),
    .prior_int(prior_int), .cr_rd_idx(cr_rd_idx), .cr_rd_data(cr_rd_data),
    .int_we(int_we), .int_waddr(int_waddr), .int_wdata(int_wdata),
    .cr_we(cr_we), .cr_waddr(cr_waddr), .cr_wbit_idx(cr_wbit_idx),
    .cr_wval(cr_wval), .cr1_we(cr1_we), .cr1_wdata(cr1_wdata),
    .busy(busy), .done(done)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic ref_reduce(input logic [3:0] m, input logic [3:0] e,
                                      input logic [3:0] f, input logic any);
    logic acc_or;
    logic acc_and;
    acc_or  = 1'b0;
    acc_and = 1'b1;
    for (int b = 0; b < 4; b++) begin
      if (m[b] && (e[b] == f[b])) acc_or = 1'b1;
      else                        acc_and = 1'b0;
    end
    return any ? acc_or : acc_and;
  endfunction

  function automatic logic [3:0] ref_summary(input logic [63:0] v);
    if (v == 64'd0)             return 4'b0010;
    else if ($signed(v) < 0)    return 4'b1000;
    else                        return 4'b0100;
  endfunction

  task automatic run_op();
    logic        exp_res [64];
    logic [63:0] exp_acc;
    int          fidx;
    int          done_k;
    exp_acc = op_prior;
    for (int i = 0; i < op_vl; i++) begin
      fidx = op_src_vec ? (op_crb + i) % 64 : op_crb;
      exp_res[i] = ref_reduce(op_mask, op_mode, crf[fidx], op_or);
      exp_acc[i] = exp_res[i];
    end
    done_k = (op_vl == 0) ? 0 : ((op_dst == 2'b00) ? op_vl + 1 : op_vl);

    @(negedge clk);
    start = 1'b1; vl = 7'(op_vl); src_vec = op_src_vec; dst_sel = op_dst;
    use_or = op_or; mask = op_mask; mode = op_mode; cr_base = 6'(op_crb);
    int_base = 5'(op_intb); bft = op_bft; rc = op_rc; prior_int = op_prior;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= done_k; k++) begin
      if (op_glitch && k == 1) begin
        start = 1'b1; mask = ~op_mask; dst_sel = 2'b10; use_or = ~op_or;
      end
      if (op_glitch && k == 2) start = 1'b0;
      #1;
      chk(done == (k == done_k), "R11", "done", 64'(done), 64'(k == done_k));
      chk(busy == (k < done_k), "R10", "busy", 64'(busy), 64'(k < done_k));
      if (k < op_vl) begin
        fidx = op_src_vec ? (op_crb + k) % 64 : op_crb;
        chk(cr_rd_idx == 6'(fidx), op_src_vec ? "R8" : "R3", "read index",
            64'(cr_rd_idx), 64'(fidx));
        case (op_dst)
          2'b00: chk(!int_we && !cr_we, "R4", "no write during run",
                     64'({int_we, cr_we}), 64'd0);
          2'b01: begin
            chk(int_we && !cr_we, "R5", "element write enable",
                64'({int_we, cr_we}), 64'd2);
            chk(int_waddr == 5'((op_intb + k) % 32), "R5", "element address",
                64'(int_waddr), 64'((op_intb + k) % 32));
            chk(int_wdata == {63'd0, exp_res[k]}, dtag, "element data",
                int_wdata, {63'd0, exp_res[k]});
          end
          default: begin
            chk(cr_we && !int_we, "R6", "bit write enable",
                64'({cr_we, int_we}), 64'd2);
            chk(cr_waddr == 6'(op_bft[2:0]) && cr_wbit_idx == 2'd3 - op_bft[4:3],
                "R6", "bit target", 64'({cr_waddr, cr_wbit_idx}),
                64'({6'(op_bft[2:0]), 2'd3 - op_bft[4:3]}));
            chk(cr_wval == exp_res[k], dtag, "bit value",
                64'(cr_wval), 64'(exp_res[k]));
          end
        endcase
        chk(!cr1_we, "R7", "no summary during run", 64'(cr1_we), 64'd0);
      end else if (op_dst == 2'b00 && op_vl > 0 && k == op_vl) begin
        chk(int_we && !cr_we, "R4", "final write enable", 64'({int_we, cr_we}), 64'd2);
        chk(int_waddr == 5'(op_intb), "R4", "final address",
            64'(int_waddr), 64'(op_intb));
        chk(int_wdata == exp_acc, dtag, "packed value", int_wdata, exp_acc);
        chk(cr1_we == op_rc, "R7", "summary enable", 64'(cr1_we), 64'(op_rc));
        if (op_rc)
          chk(cr1_wdata == ref_summary(exp_acc), "R7", "summary code",
              64'(cr1_wdata), 64'(ref_summary(exp_acc)));
      end else begin
        chk(!int_we && !cr_we && !cr1_we, (op_vl == 0) ? "R9" : "R11",
            "no write at end", 64'({int_we, cr_we, cr1_we}), 64'd0);
      end
      @(negedge clk);
    end
    #1;
    chk(!done && !busy, "R11", "single done pulse", 64'({done, busy}), 64'd0);
  endtask

  task automatic set_op(input int n, input logic sv, input logic [1:0] d,
                        input logic o, input logic [3:0] m, input logic [3:0] e,
                        input int cb, input int ib, input logic [4:0] t,
                        input logic r, input logic [63:0] p, input string tg);
    op_vl = n; op_src_vec = sv; op_dst = d; op_or = o; op_mask = m;
    op_mode = e; op_crb = cb; op_intb = ib; op_bft = t; op_rc = r;
    op_prior = p; op_glitch = 1'b0; dtag = tg;
  endtask

  task automatic t_reset();
    #1;
    chk(!busy && !done, "R10", "reset idle", 64'({busy, done}), 64'd0);
    chk(!int_we && !cr_we && !cr1_we, "R10", "reset writes",
        64'({int_we, cr_we, cr1_we}), 64'd0);
  endtask

  task automatic t_scalar_or_restart();
    set_op(10, 1'b1, 2'b00, 1'b1, 4'b0101, 4'b0100, 5, 3, 5'd0, 1'b1,
           64'hA5A5_A5A5_5A5A_5A5A, "R2");
    op_glitch = 1'b1;
    run_op();
  endtask

  task automatic t_vec_and_wrap();
    set_op(8, 1'b1, 2'b01, 1'b0, 4'b1111, 4'b0011, 0, 30, 5'd0, 1'b1, 64'd0, "R1");
    run_op();
  endtask

  task automatic t_full_scalar_wrap();
    set_op(64, 1'b1, 2'b00, 1'b0, 4'b0110, 4'b0010, 60, 7, 5'd0, 1'b1, 64'd0, "R2");
    run_op();
  endtask

  task automatic t_scalar_source();
    set_op(5, 1'b0, 2'b00, 1'b1, 4'b1000, 4'b1000, 9, 12, 5'd0, 1'b1, '1, "R3");
    run_op();
  endtask

  task automatic t_cr_dest();
    set_op(3, 1'b1, 2'b10, 1'b1, 4'b0011, 4'b0001, 12, 0, 5'b10110, 1'b1, 64'd0, "R6");
    run_op();
  endtask

  task automatic t_vl_zero();
    set_op(0, 1'b1, 2'b00, 1'b1, 4'b1111, 4'b0000, 0, 0, 5'd0, 1'b1, 64'd5, "R9");
    run_op();
  endtask

  task automatic t_summary_codes();
    set_op(4, 1'b1, 2'b00, 1'b0, 4'b0000, 4'b0000, 20, 2, 5'd0, 1'b1, 64'd0, "R7");
    run_op();
    set_op(3, 1'b1, 2'b00, 1'b1, 4'b0000, 4'b0000, 20, 2, 5'd0, 1'b1, 64'h10, "R7");
    run_op();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int j = 0; j < 64; j++) crf[j] = 4'((j * 5 + 3) ^ (j >> 2));
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_scalar_or_restart();
    t_vec_and_wrap();
    t_full_scalar_wrap();
    t_scalar_source();
    t_cr_dest();
    t_vl_zero();
    t_summary_codes();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule